// File: doc/BRIEF.md
# Dual Programmable Timer Unit

This block holds two independent 32-bit down-counters. Software reaches them through word-aligned memory-mapped registers. Each timer has three registers: a mode word, a reload value and the live count. A timer counts on ticks of its own prescaler, which divides the block clock by 1, 2, 4 or 8. When its count reaches zero, the timer raises a one-cycle interrupt pulse on its own output line. In single-shot mode the timer then stops. In auto-reload mode it refills from the reload register on the next tick and keeps running.

Every register write carries a privilege flag. A timer can be marked supervisor-only through its mode word. After that, user-mode writes to any of its registers are discarded and a one-cycle fault strobe is raised. Supervisor writes are always accepted. Reads are not privilege-checked. Read data is registered and appears one cycle after the address is presented.

Top module: `dual_timer_unit`

## Requirements
- R1: Timer `t` occupies byte addresses `t*16` to `t*16+15`. Word 0 is the mode register, word 1 is the reload register and word 2 is the count register, selected by address bits [3:2]. The low two address bits are ignored. `bus_rdata` shows the addressed register one clock after the address is presented. Word 3 and all undefined mode bits read as zero.
- R2: The mode register fields are: bit 0 run, bit 1 auto-reload, bits [3:2] prescale select, bit 4 supervisor-only. Written fields read back unchanged.
- R3: While run is set, the count moves once every 2^sel clocks, where sel is the prescale select. The first move comes 2^sel clocks after the write that sets run.
- R4: In single-shot mode (bit 1 = 0), the tick that takes the count from 1 to 0 drives that timer's `irq` bit high for exactly one cycle and clears the run bit. The count stays at 0.
- R5: In auto-reload mode (bit 1 = 1), the timer loads the reload value on the tick after reaching zero and keeps running. Interrupts therefore repeat every (reload+1)·2^sel clocks.
- R6: A count write while the timer is stopped takes effect at once. A count write while it runs is held and replaces the count on the next prescaler tick, in place of that tick's decrement.
- R7: When bit 4 of a timer's mode register is set, a user-mode write (`bus_user`=1) to any of that timer's registers changes nothing and raises `fault` for one cycle, in the cycle after the write.
- R8: Supervisor-mode writes always take effect without a fault. User-mode writes to a timer whose bit 4 is clear also take effect without a fault.
- R9: The two timers are independent. Running or writing one never moves the other's count or irq.
- R10: After a synchronous reset, all registers read zero and `irq` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_user | input | 1 | 1 = the write comes from user mode |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 2 | Per-timer one-cycle interrupt pulse |
| fault | output | 1 | One-cycle strobe for a rejected user-mode write |

## Verification
Every result here is due at a fixed offset from the write edge:
- Read data arrives one clock after the address.
- A fault shows in the cycle straight after the rejected write.
- A count-to-zero interrupt appears exactly count·2^sel clocks after the write that sets run.
- An auto-reload repeat comes (reload+1)·2^sel clocks after the previous pulse.

The bench drives each write at a falling edge and counts falling edges until the pulse appears. It compares that count with the product computed from the programmed values, for every prescale setting and several counts on both timers. A mid-run count write is timed from its own edge: the next tick boundary, plus the new count times the divider.

// File: rtl/tu_pkg.sv
package tu_pkg;
  localparam int TU_DATA_W = 32;
  localparam int TU_SEL_W  = 2;

  typedef enum logic [1:0] {
    W_MODE   = 2'd0,
    W_RELOAD = 2'd1,
    W_COUNT  = 2'd2,
    W_NONE   = 2'd3
  } tu_word_e;

  typedef struct packed {
    logic                supv;
    logic [TU_SEL_W-1:0] psel;
    logic                autold;
    logic                run;
  } tu_mode_t;

  localparam int TU_MODE_W = $bits(tu_mode_t);
endpackage

// File: rtl/tu_prescaler.sv
module tu_prescaler #(
  parameter int SEL_W = 2,
  localparam int PC_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] psel,
  output logic             tick
);
  logic [PC_W-1:0] pre_cnt;
  logic [PC_W-1:0] limit;

  always_comb begin
    limit = PC_W'((32'd1 << psel) - 32'd1);
    tick  = run && (pre_cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) pre_cnt <= '0;
    else                     pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/tu_channel.sv
module tu_channel
  import tu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_mode,
  input  logic             wr_reload,
  input  logic             wr_count,
  input  logic [CNT_W-1:0] wdata,
  output tu_mode_t         mode_q,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] count_q,
  output logic             irq
);
  logic             tick;
  logic             pend_v;
  logic [CNT_W-1:0] pend_val;

  tu_prescaler #(.SEL_W(TU_SEL_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (mode_q.run),
    .psel (mode_q.psel),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      reload_q <= '0;
      count_q  <= '0;
      pend_v   <= 1'b0;
      pend_val <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      // terminal behaviour and counting on each prescaled tick
      if (tick) begin
        if (pend_v) begin
          count_q <= pend_val;
          pend_v  <= 1'b0;
        end else if (count_q == '0) begin
          if (mode_q.autold) count_q    <= reload_q;
          else               mode_q.run <= 1'b0;
        end else begin
          count_q <= count_q - 1'b1;
          if (count_q == CNT_W'(1)) begin
            irq <= 1'b1;
            if (!mode_q.autold) mode_q.run <= 1'b0;
          end
        end
      end else if (!mode_q.run && pend_v) begin
        count_q <= pend_val;
        pend_v  <= 1'b0;
      end
      // register writes take priority over the counting path
      if (wr_mode)   mode_q   <= tu_mode_t'(wdata[TU_MODE_W-1:0]);
      if (wr_reload) reload_q <= wdata;
      if (wr_count) begin
        if (mode_q.run) begin
          pend_val <= wdata;
          pend_v   <= 1'b1;
        end else begin
          count_q  <= wdata;
          pend_v   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import tu_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  localparam int TSEL_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W = TSEL_W + 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wen,
  input  logic [TU_DATA_W-1:0]  bus_wdata,
  input  logic                  bus_user,
  output logic [TU_DATA_W-1:0]  bus_rdata,
  output logic [NUM_TIMERS-1:0] irq,
  output logic                  fault
);
  tu_word_e              word;
  logic [TSEL_W-1:0]     tsel;
  tu_mode_t              mode_q   [NUM_TIMERS];
  logic [TU_DATA_W-1:0]  reload_q [NUM_TIMERS];
  logic [TU_DATA_W-1:0]  count_q  [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] deny;
  logic                  fault_d;
  logic [TU_DATA_W-1:0]  rd_d;

  assign word = tu_word_e'(bus_addr[3:2]);
  assign tsel = bus_addr[ADDR_W-1:4];

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    logic hit, blocked;
    assign hit     = bus_wen && (tsel == TSEL_W'(i)) && (word != W_NONE);
    assign blocked = bus_user && mode_q[i].supv;
    assign deny[i] = hit && blocked;

    tu_channel #(.CNT_W(TU_DATA_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_mode   (hit && !blocked && (word == W_MODE)),
      .wr_reload (hit && !blocked && (word == W_RELOAD)),
      .wr_count  (hit && !blocked && (word == W_COUNT)),
      .wdata     (bus_wdata),
      .mode_q    (mode_q[i]),
      .reload_q  (reload_q[i]),
      .count_q   (count_q[i]),
      .irq       (irq[i])
    );
  end

  assign fault_d = |deny;

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (tsel == TSEL_W'(i)) begin
        case (word)
          W_MODE:   rd_d = TU_DATA_W'(mode_q[i]);
          W_RELOAD: rd_d = reload_q[i];
          W_COUNT:  rd_d = count_q[i];
          default:  rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      fault     <= 1'b0;
    end else begin
      bus_rdata <= rd_d;
      fault     <= fault_d;
    end
  end
endmodule

// File: rtl/tu_checker.sv
module tu_checker #(
  parameter int NUM_TIMERS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wen,
  input logic                  bus_user,
  input logic [NUM_TIMERS-1:0] irq,
  input logic                  fault
);
  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    // R4: interrupt is a single-cycle pulse
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      irq[i] |=> !irq[i]);
  end

  // R7: a fault only follows a user-mode write
  p_fault_cause_r7: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(bus_wen && bus_user));

  // R8: supervisor writes never fault
  p_supv_no_fault_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && !bus_user) |=> !fault);

  // R7: fault never holds two cycles without two writes
  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (fault && !(bus_wen && bus_user)) |=> !fault);

  // R10: outputs idle after reset
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (irq == '0) && !fault);
endmodule

bind dual_timer_unit tu_checker #(.NUM_TIMERS(NUM_TIMERS)) u_tu_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wen  (bus_wen),
  .bus_user (bus_user),
  .irq      (irq),
  .fault    (fault)
);

// File: tb/dual_timer_unit_test.sv
module dual_timer_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic        bus_user;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;
  logic        fault;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  int other_irq;

  always #10 clk = ~clk;

  dual_timer_unit uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_user(bus_user), .bus_rdata(bus_rdata),
    .irq(irq), .fault(fault)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int t, int w, logic [31:0] d, bit user);
    bus_addr  = 5'(t * 16 + w * 4);
    bus_wdata = d;
    bus_user  = user;
    bus_wen   = 1'b1;
    @(negedge clk);
    bus_wen   = 1'b0;
    bus_user  = 1'b0;
  endtask

  task automatic rd(int t, int w, output logic [31:0] d);
    bus_addr = 5'(t * 16 + w * 4);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_irq(int t, int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (irq[1-t]) other_irq++;
    end while (!irq[t] && n < limit);
  endtask

  initial begin
    logic [31:0] d;
    int n, dv;
    rst = 1'b1; bus_addr = '0; bus_wen = 0; bus_wdata = '0; bus_user = 0;
    other_irq = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk("R10 irq", 32'(irq), 0);
    chk("R10 fault", 32'(fault), 0);
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 3; w++) begin
        rd(t, w, d);
        chk("R10 reg", d, 0);
      end

    // R1/R2 register readback and masking
    wr(0, 0, 32'hFFFF_FFE0, 0); rd(0, 0, d); chk("R1 mode mask", d, 0);
    wr(0, 0, 32'h1A, 0);        rd(0, 0, d); chk("R2 mode fields", d, 32'h1A);
    wr(0, 0, 32'h0, 0);
    wr(1, 1, 32'hDEAD_BEEF, 0); rd(1, 1, d); chk("R1 reload", d, 32'hDEAD_BEEF);
    rd(1, 3, d);                             chk("R1 word3", d, 0);
    wr(1, 2, 32'h1234_5678, 0); rd(1, 2, d); chk("R6 stopped count", d, 32'h1234_5678);
    rd(0, 2, d);                             chk("R9 other count", d, 0);
    wr(1, 1, 32'h0, 0);

    // R3/R4/R9 single-shot sweep
    for (int t = 0; t < 2; t++)
      for (int ps = 0; ps < 4; ps++)
        for (int c = 1; c <= 3; c++) begin
          dv = 1 << ps;
          other_irq = 0;
          wr(t, 2, 32'(c), 0);
          wr(t, 0, 32'(1 | (ps << 2)), 0);
          wait_irq(t, 100, n);
          chk("R3 single-shot timing", 32'(n), 32'(c * dv));
          @(negedge clk);
          chk("R4 pulse width", 32'(irq[t]), 0);
          rd(t, 0, d); chk("R4 run cleared", d, 32'(ps << 2));
          rd(t, 2, d); chk("R4 count zero", d, 0);
          chk("R9 other quiet", 32'(other_irq), 0);
        end

    // R5 auto-reload period
    for (int ps = 0; ps < 4; ps++) begin
      dv = 1 << ps;
      wr(0, 1, 32'd3, 0);
      wr(0, 2, 32'd2, 0);
      wr(0, 0, 32'(3 | (ps << 2)), 0);
      wait_irq(0, 200, n); chk("R5 first period", 32'(n), 32'(2 * dv));
      wait_irq(0, 200, n); chk("R5 repeat period", 32'(n), 32'(4 * dv));
      wait_irq(0, 200, n); chk("R5 repeat again", 32'(n), 32'(4 * dv));
      wr(0, 0, 32'h0, 0);
    end

    // R6 count write while running
    wr(1, 2, 32'd100, 0);
    wr(1, 0, 32'(1 | (3 << 2)), 0);
    @(negedge clk); @(negedge clk);
    wr(1, 2, 32'd5, 0);
    wait_irq(1, 500, n);
    chk("R6 running count write", 32'(n), 32'd45);

    // R7/R8 privilege
    wr(1, 0, 32'h10, 0);
    chk("R8 supervisor no fault", 32'(fault), 0);
    wr(1, 1, 32'h55, 1);
    chk("R7 fault pulse", 32'(fault), 1);
    @(negedge clk);
    chk("R7 fault single cycle", 32'(fault), 0);
    rd(1, 1, d); chk("R7 write dropped", d, 0);
    wr(1, 0, 32'h0, 1);
    chk("R7 mode fault", 32'(fault), 1);
    rd(1, 0, d); chk("R7 mode kept", d, 32'h10);
    wr(1, 1, 32'h77, 0);
    chk("R8 supervisor write", 32'(fault), 0);
    rd(1, 1, d); chk("R8 supervisor value", d, 32'h77);
    wr(0, 1, 32'h33, 1);
    chk("R8 unprotected user", 32'(fault), 0);
    rd(0, 1, d); chk("R8 unprotected value", d, 32'h33);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule